// File: doc/BRIEF.md
# I2C 16-bit Quasi-Bidirectional Port Expander

This block is an I2C slave that owns a 16-bit latched port. Each port pin is either pulled low by the latch or released. A released pin reads back whatever the outside world drives onto it, so writing a 1 to a bit turns that pin into an input. There is no separate direction register. The master writes the port two bytes at a time: low half first, then high half. It reads the sampled pin levels back in the same order. A read goes on for as long as the master keeps acknowledging.

SCL and SDA enter as plain levels. A synchronizer in the block's own clock domain oversamples them. SDA is driven open-drain through a single pull-low enable. The slave address comes from three strap pins, each of which an outside sampler reports as a 2-bit code, so 64 addresses can be selected. Three events reset the latch to all ones: the synchronous reset, an active-low reset pin, and a software reset sequence sent through the general call address.

Top module: `i2cx_expander`

## Requirements
- R1: While `rst` is high, or two clock cycles after `hw_rst_n` is seen low, `pin_drv` is all ones and `sda_oe` is 0.
- R2: Strap codes are 0 = ground, 1 = supply, 2 = tied to SCL, 3 = tied to SDA. The 7-bit slave address is `{strap_code[5:0], 1'b0}`. The block pulls SDA low during the 9th clock of a matching address byte.
- R3: The block never acknowledges an address byte whose 7 address bits differ from its own. It also never acknowledges its own address when the straps select the reserved value 7'h00 or 7'h7C, except for the general-call write used by R8.
- R4: In a write, the first data byte goes to `pin_drv[7:0]` and the second to `pin_drv[15:8]`. Further bytes keep alternating between the low and high halves.
- R5: A written byte reaches `pin_drv` only after the falling SCL edge that ends its acknowledge clock. During that acknowledge clock the pins still hold their old value.
- R6: A read returns `pin_sense[7:0]`, then `pin_sense[15:8]`, alternating, MSB first. Each byte is sampled at the rising SCL edge of the acknowledge clock that comes before it. The read stops after a master NACK.
- R7: A START or STOP that arrives in the middle of a byte ends the transfer and leaves `pin_drv` unchanged.
- R8: A general call write (byte 8'h00), followed by data byte 8'h06 and then a STOP, sets `pin_drv` to all ones. Any other first data byte after the general call is not acknowledged and causes no reset.
- R9: `sda_oe` only begins to pull SDA low while SCL is low. `sda_oe` is 0 after every STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| hw_rst_n | input | 1 | Active-low reset pin |
| scl_i | input | 1 | SCL level |
| sda_i | input | 1 | SDA level (wired bus) |
| sda_oe | output | 1 | 1 = pull SDA low |
| strap_code | input | 6 | Strap codes: [5:4] pin 2, [3:2] pin 1, [1:0] pin 0 |
| pin_sense | input | 16 | Sensed port pin levels |
| pin_drv | output | 16 | Port latch: 0 = pull low, 1 = released |

## Verification
The latch can be hit by a data-byte write and by a reset in close succession. The case the bench provokes is a software reset whose sequence is complete up to the STOP. At that point the port still holds written data, and the bench judges that the pins change only at the STOP and never at the acknowledge of 8'h06. A second case is a STOP or a repeated START that lands partway through a data byte, while a byte value is already shifted in. The bench checks that the latch keeps its previous value, with the expected word held in its own port model.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_RX, S_WACK, S_TX, S_MACK
  } xfer_st_t;

  localparam logic [6:0] GCALL_ADDR  = 7'h00;
  localparam logic [6:0] DEVID_ADDR  = 7'h7C;
  localparam logic [7:0] SWRST_BYTE  = 8'h06;
endpackage

// File: rtl/i2cx_bus_sense.sv
module i2cx_bus_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s     = scl_sh[SYNC_STAGES-1];
  assign sda_s     = sda_sh[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cx_strap_map.sv
module i2cx_strap_map
  import i2cx_pkg::*;
#(
  parameter int STRAP_PINS = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [2*STRAP_PINS-1:0] strap_code,
  output logic [6:0]              own_addr,
  output logic                    own_rsv
);
  localparam int ADDR_W = 7;
  logic [ADDR_W-1:0] addr_c;

  // Each strap pin contributes its 2-bit code; LSB is fixed at 0.
  always_comb begin
    addr_c = '0;
    for (int p = 0; p < STRAP_PINS; p++)
      addr_c[2*p+1 +: 2] = strap_code[2*p +: 2];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_addr <= GCALL_ADDR;
      own_rsv  <= 1'b1;
    end else begin
      own_addr <= addr_c;
      own_rsv  <= (addr_c == GCALL_ADDR) || (addr_c == DEVID_ADDR);
    end
  end
endmodule

// File: rtl/i2cx_port_latch.sv
module i2cx_port_latch #(
  parameter int PORT_W = 16,
  parameter int NBYTES = PORT_W / 8,
  parameter int SEL_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [7:0]        wr_byte,
  output logic [PORT_W-1:0] pin_drv
);
  for (genvar g = 0; g < NBYTES; g++) begin : g_half
    logic [7:0] byte_q;
    always_ff @(posedge clk) begin
      if (rst || clr)
        byte_q <= 8'hFF;
      else if (wr_en && (wr_sel == SEL_W'(g)))
        byte_q <= wr_byte;
    end
    assign pin_drv[g*8 +: 8] = byte_q;
  end
endmodule

// File: rtl/i2cx_slave_ctrl.sv
module i2cx_slave_ctrl
  import i2cx_pkg::*;
#(
  parameter int PORT_W = 16,
  parameter int NBYTES = PORT_W / 8,
  parameter int SEL_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [6:0]        own_addr,
  input  logic              own_rsv,
  input  logic [PORT_W-1:0] pin_sense,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [SEL_W-1:0]  wr_sel,
  output logic [7:0]        wr_byte,
  output logic              swrst
);
  xfer_st_t   st;
  logic [3:0] bitcnt;
  logic [7:0] shreg, txsh;
  logic       rw, gc, mack, swrst_pend;
  logic [SEL_W-1:0] sel, sel_nx;

  assign sel_nx = (int'(sel) == NBYTES - 1) ? '0 : sel + 1'b1;

  function automatic logic [7:0] sense_byte(input logic [PORT_W-1:0] v, input int idx);
    return v[idx*8 +: 8];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; bitcnt <= '0; shreg <= '0; txsh <= '0;
      rw <= 1'b0; gc <= 1'b0; mack <= 1'b0; swrst_pend <= 1'b0;
      sel <= '0; sda_oe <= 1'b0; wr_en <= 1'b0; wr_sel <= '0;
      wr_byte <= '0; swrst <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      swrst <= 1'b0;
      if (start_evt) begin
        st <= S_ADDR; bitcnt <= '0; sda_oe <= 1'b0;
        gc <= 1'b0; swrst_pend <= 1'b0;
      end else if (stop_evt) begin
        st <= S_IDLE; sda_oe <= 1'b0;
        swrst <= swrst_pend; swrst_pend <= 1'b0;
      end else begin
        unique case (st)
          S_ADDR, S_RX: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (st == S_ADDR) begin
                if (shreg[7:1] == own_addr && !own_rsv) begin
                  sda_oe <= 1'b1; rw <= shreg[0]; gc <= 1'b0;
                  sel <= '0; st <= S_AACK;
                end else if (shreg == {GCALL_ADDR, 1'b0}) begin
                  sda_oe <= 1'b1; rw <= 1'b0; gc <= 1'b1; st <= S_AACK;
                end else begin
                  st <= S_IDLE;
                end
              end else if (!gc || shreg == SWRST_BYTE) begin
                sda_oe <= 1'b1; st <= S_WACK;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          S_AACK: begin
            if (scl_rise && rw) txsh <= sense_byte(pin_sense, int'(sel));
            if (scl_fall) begin
              bitcnt <= '0;
              if (rw) begin
                sda_oe <= ~txsh[7]; st <= S_TX;
              end else begin
                sda_oe <= 1'b0; st <= S_RX;
              end
            end
          end
          S_WACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0; bitcnt <= '0;
              if (gc) begin
                swrst_pend <= 1'b1; st <= S_IDLE;
              end else begin
                wr_en <= 1'b1; wr_byte <= shreg; wr_sel <= sel;
                sel <= sel_nx; st <= S_RX;
              end
            end
          end
          S_TX: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                sda_oe <= 1'b0; st <= S_MACK;
              end else begin
                txsh   <= {txsh[6:0], 1'b0};
                sda_oe <= ~txsh[6];
                bitcnt <= bitcnt + 4'd1;
              end
            end
          end
          S_MACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
              if (!sda_s) begin
                sel  <= sel_nx;
                txsh <= sense_byte(pin_sense, int'(sel_nx));
              end
            end else if (scl_fall) begin
              bitcnt <= '0;
              if (mack) begin
                sda_oe <= ~txsh[7]; st <= S_TX;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cx_expander.sv
module i2cx_expander #(
  parameter int PORT_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int STRAP_PINS  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    hw_rst_n,
  input  logic                    scl_i,
  input  logic                    sda_i,
  output logic                    sda_oe,
  input  logic [2*STRAP_PINS-1:0] strap_code,
  input  logic [PORT_W-1:0]       pin_sense,
  output logic [PORT_W-1:0]       pin_drv
);
  localparam int NBYTES = PORT_W / 8;
  localparam int SEL_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  logic rst_pin_q, core_rst;
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic [6:0] own_addr;
  logic own_rsv, wr_en, swrst;
  logic [SEL_W-1:0] wr_sel;
  logic [7:0] wr_byte;

  always_ff @(posedge clk) begin
    if (rst) rst_pin_q <= 1'b0;
    else     rst_pin_q <= ~hw_rst_n;
  end
  assign core_rst = rst | rst_pin_q;

  i2cx_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) sense_i (
    .clk(clk), .rst(core_rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt));

  i2cx_strap_map #(.STRAP_PINS(STRAP_PINS)) strap_i (
    .clk(clk), .rst(core_rst), .strap_code(strap_code),
    .own_addr(own_addr), .own_rsv(own_rsv));

  i2cx_slave_ctrl #(.PORT_W(PORT_W)) ctrl_i (
    .clk(clk), .rst(core_rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .own_addr(own_addr), .own_rsv(own_rsv), .pin_sense(pin_sense),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_sel(wr_sel), .wr_byte(wr_byte),
    .swrst(swrst));

  i2cx_port_latch #(.PORT_W(PORT_W)) latch_i (
    .clk(clk), .rst(core_rst), .clr(swrst), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_byte(wr_byte), .pin_drv(pin_drv));
endmodule

// File: rtl/i2cx_expander_chk.sv
module i2cx_expander_chk #(
  parameter int PORT_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              hw_rst_n,
  input logic              core_rst,
  input logic              scl_s,
  input logic              scl_fall,
  input logic              stop_evt,
  input logic              sda_oe,
  input logic              wr_en,
  input logic              swrst,
  input logic [PORT_W-1:0] pin_drv
);
  // R1: reset pin releases the whole port
  p_pin_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(!hw_rst_n) |=> (pin_drv == '1));

  // R9: pull-low only begins while SCL is low
  p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_s);

  // R9: bus released after STOP
  p_oe_stop_r9: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> !sda_oe);

  // R5: a latch write follows a falling SCL edge
  p_write_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(scl_fall));

  // R7: the port changes only through a write or a reset
  p_port_source_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(pin_drv) |-> $past(wr_en || swrst || core_rst));

  // R8: software reset releases the whole port
  p_swrst_r8: assert property (@(posedge clk) disable iff (rst)
    swrst |=> (pin_drv == '1));
endmodule

bind i2cx_expander i2cx_expander_chk #(.PORT_W(PORT_W)) chk_i (
  .clk(clk), .rst(rst), .hw_rst_n(hw_rst_n), .core_rst(core_rst),
  .scl_s(scl_s), .scl_fall(scl_fall), .stop_evt(stop_evt), .sda_oe(sda_oe),
  .wr_en(wr_en), .swrst(swrst), .pin_drv(pin_drv));

// File: tb/i2cx_expander_tb_top.sv
module i2cx_expander_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam int WDOG       = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1, hw_rst_n = 1'b1, scl_m = 1'b1, sda_m = 1'b1;
  logic [5:0]  strap = 6'h15;
  logic [15:0] sense_ext = 16'hFFFF, exp_drv = 16'hFFFF;
  logic sda_oe, sda_line;
  logic [15:0] pin_drv, pin_sense;
  int n_checks = 0, n_fail = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line  = sda_m & ~sda_oe;
  assign pin_sense = sense_ext & pin_drv;

  i2cx_expander dut_i (
    .clk(clk), .rst(rst), .hw_rst_n(hw_rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .strap_code(strap), .pin_sense(pin_sense), .pin_drv(pin_drv));

  function automatic logic [7:0] addr_byte(input logic [5:0] s, input logic rd);
    return {s, 1'b0, rd};
  endfunction

  function automatic logic [7:0] exp_rd(input int idx);
    logic [15:0] v;
    v = sense_ext & exp_drv;
    return v[idx*8 +: 8];
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n); repeat (n) @(negedge clk); endtask

  task automatic i2c_start();
    sda_m = 1'b1; wclk(Q); scl_m = 1'b1; wclk(Q);
    sda_m = 1'b0; wclk(Q); scl_m = 1'b0; wclk(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wclk(Q); scl_m = 1'b1; wclk(Q); sda_m = 1'b1; wclk(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wclk(Q); scl_m = 1'b1; wclk(2*Q); scl_m = 1'b0; wclk(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wclk(Q); scl_m = 1'b1; wclk(Q); b = sda_line;
    wclk(Q); scl_m = 1'b0; wclk(Q);
  endtask

  // sends a byte; returns slave ack and pin_drv seen during the ack clock
  task automatic put_byte(input logic [7:0] d, output logic ack, output logic [15:0] drv_in_ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    sda_m = 1'b1; wclk(Q); scl_m = 1'b1; wclk(Q);
    b = sda_line; drv_in_ack = pin_drv;
    wclk(Q); scl_m = 1'b0; wclk(Q);
    ack = ~b;
  endtask

  task automatic get_byte(input logic m_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    put_bit(~m_ack);
  endtask

  task automatic do_write(input logic [7:0] bytes[4], input int n);
    logic ack; logic [15:0] snap;
    i2c_start();
    put_byte(addr_byte(strap, 1'b0), ack, snap);
    check(ack, "R2 write address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      put_byte(bytes[i], ack, snap);
      check(snap == exp_drv, "R5 pins hold during ack", snap, exp_drv);
      if (i % 2 == 0) exp_drv[7:0] = bytes[i]; else exp_drv[15:8] = bytes[i];
      check(pin_drv == exp_drv, "R4 byte lands in its half", pin_drv, exp_drv);
    end
    i2c_stop();
  endtask

  task automatic do_read(input int n);
    logic ack; logic [15:0] snap; logic [7:0] d;
    i2c_start();
    put_byte(addr_byte(strap, 1'b1), ack, snap);
    check(ack, "R2 read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      get_byte(i != n - 1, d);
      check(d == exp_rd(i % 2), "R6 read byte", d, exp_rd(i % 2));
    end
    check(sda_oe == 1'b0, "R6 released after NACK", sda_oe, 0);
    i2c_stop();
    check(sda_oe == 1'b0, "R9 released after STOP", sda_oe, 0);
  endtask

  initial begin : watchdog
    while (cyc < WDOG) begin @(posedge clk); cyc++; end
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WDOG);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    logic ack; logic [15:0] snap;
    logic [7:0] wb[4];
    void'($urandom(32'd20240611));
    wclk(5); rst = 1'b0; wclk(4);
    check(pin_drv == 16'hFFFF, "R1 reset port", pin_drv, 16'hFFFF);
    check(sda_oe == 1'b0, "R1 reset sda", sda_oe, 0);

    // directed write with alternation
    wb = '{8'h5A, 8'hC3, 8'h0F, 8'hE1};
    do_write(wb, 3);
    sense_ext = 16'hA5F0;
    do_read(3);

    // wrong address
    i2c_start(); put_byte(addr_byte(strap ^ 6'h01, 1'b0), ack, snap);
    check(!ack, "R3 foreign address nack", ack, 0); i2c_stop();

    // mid-byte STOP and mid-byte START
    i2c_start(); put_byte(addr_byte(strap, 1'b0), ack, snap);
    for (int i = 0; i < 5; i++) put_bit(1'b0);
    i2c_stop(); wclk(Q);
    check(pin_drv == exp_drv, "R7 stop mid-byte", pin_drv, exp_drv);
    i2c_start(); put_byte(addr_byte(strap, 1'b0), ack, snap);
    for (int i = 0; i < 3; i++) put_bit(1'b1);
    i2c_start(); i2c_stop(); wclk(Q);
    check(pin_drv == exp_drv, "R7 start mid-byte", pin_drv, exp_drv);

    // hardware reset pin
    hw_rst_n = 1'b0; wclk(3); hw_rst_n = 1'b1; wclk(3);
    exp_drv = 16'hFFFF;
    check(pin_drv == 16'hFFFF, "R1 reset pin", pin_drv, 16'hFFFF);

    // software reset: wrong byte, then correct sequence
    wb = '{8'h34, 8'h12, 8'h00, 8'h00};
    do_write(wb, 2);
    i2c_start(); put_byte(8'h00, ack, snap);
    check(ack, "R8 general call ack", ack, 1);
    put_byte(8'h07, ack, snap);
    check(!ack, "R8 wrong reset byte nack", ack, 0);
    i2c_stop(); wclk(Q);
    check(pin_drv == exp_drv, "R8 no reset on wrong byte", pin_drv, exp_drv);
    i2c_start(); put_byte(8'h00, ack, snap); put_byte(8'h06, ack, snap);
    check(ack, "R8 reset byte ack", ack, 1);
    wclk(Q);
    check(pin_drv == exp_drv, "R8 port held until STOP", pin_drv, exp_drv);
    i2c_stop(); wclk(Q); exp_drv = 16'hFFFF;
    check(pin_drv == 16'hFFFF, "R8 software reset", pin_drv, 16'hFFFF);

    // reserved strap values
    strap = 6'h00; wclk(4);
    i2c_start(); put_byte(8'h01, ack, snap);
    check(!ack, "R3 reserved 00 read nack", ack, 0); i2c_stop();
    strap = 6'h3E; wclk(4);
    i2c_start(); put_byte(8'hF8, ack, snap);
    check(!ack, "R3 reserved 7C nack", ack, 0); i2c_stop();

    // constrained random traffic
    for (int t = 0; t < 40; t++) begin
      logic [5:0] s;
      s = 6'($urandom_range(1, 61));
      strap = s; wclk(4);
      if ($urandom_range(0, 1) == 1) begin
        for (int k = 0; k < 4; k++) wb[k] = 8'($urandom());
        do_write(wb, $urandom_range(1, 4));
      end else begin
        sense_ext = 16'($urandom());
        do_read($urandom_range(1, 4));
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule